// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a write-through data cache and main memory. Stores leave the processor at once and wait in a small circular queue. The queue then sends them to memory one at a time, oldest first, so the processor does not stall while the queue has a free slot.

A read miss does not have to wait for the pending stores to finish. Its address is compared with every occupied slot of the queue. If any slot matches, the data of the youngest matching store is returned at once, and memory is not accessed. If no slot matches, the read goes to memory ahead of the queued stores. A build-time parameter selects a conservative ordering instead: a read miss waits until the queue is empty, then goes to memory, and the address comparison is not used.

The memory side is a single request/acknowledge port. The request holds until it is acknowledged, and only one transaction is outstanding at a time.

Top module: `store_queue_bypass`

## Requirements
- R1: After reset, `st_ready` is 1, `mem_req` is 0 and `rd_done` is 0.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly while all `DEPTH` slots are occupied, and a store offered in that state waits until a slot drains.
- R3: Queued stores reach memory in the order they were accepted, one transaction at a time, each as a request with `mem_we`=1. A slot is freed only when its `mem_ack` arrives.
- R4: In bypass mode (`WAIT_EMPTY`=0), a read miss that matches an occupied slot completes with `rd_done`=1 and `rd_fwd`=1 in the cycle after the memory port is idle. It returns the buffered data and produces no memory transaction.
- R5: When several occupied slots hold the read address, the data comes from the slot accepted most recently.
- R6: In bypass mode, a read miss with no match is issued as a memory read (`mem_we`=0) the next time the port is idle. It goes ahead of every store still queued.
- R7: With `WAIT_EMPTY`=1, a read miss is sent to memory only when the queue is empty. All earlier stores drain first, and the result always has `rd_fwd`=0, even if a slot held the address.
- R8: A memory read ends with `rd_done`=1, `rd_fwd`=0 and `rd_data` equal to the `mem_rdata` sampled with `mem_ack`, one cycle after that acknowledge. `rd_done` is a single-cycle pulse.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Queue can take a store this cycle |
| rd_valid | input | 1 | Read miss pending; held until `rd_done` is seen |
| rd_addr | input | ADDR_W | Read miss address, stable while `rd_valid` |
| rd_done | output | 1 | One-cycle pulse: read result valid |
| rd_data | output | DATA_W | Read result |
| rd_fwd | output | 1 | Result was taken from the queue |
| mem_req | output | 1 | Memory transaction requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench holds the memory so that stores pile up behind a stalled drain, then releases it with a read miss already waiting. The read is then serviced in the exact cycle after a slot is freed.

The cases covered, and what a faulty design would do in each:
- A read of the slot that just drained: a design that compares against stale slots would forward old data instead of reading memory.
- Duplicate addresses in the queue: an oldest-first priority picker would return superseded data.
- A non-matching miss: a missing read priority would put the memory read behind the queued stores in the transaction log.
- A full queue: a design without the stall would overwrite the oldest slot.
- Ordered mode: a design that ignores the parameter would forward data, or read before the queue is empty.

// File: rtl/sqb_pkg.sv
package sqb_pkg;

    // Memory port sequencer states
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_WRITE = 2'd2
    } port_state_e;

    // Ring index advance that works for any depth, power of two or not
    function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                             int unsigned depth);
        int unsigned s;
        s = base + off;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/sqb_queue.sv
module sqb_queue
    import sqb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] slot_addr [DEPTH],
    output logic [DATA_W-1:0] slot_data [DEPTH],
    output logic [DEPTH-1:0]  slot_vld,
    output logic [PW-1:0]     head,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t            mem_q [DEPTH];
    logic [PW-1:0]    tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail     <= '0;
            count    <= '0;
            slot_vld <= '0;
        end else begin
            if (push) begin
                mem_q[tail]    <= '{addr: push_addr, data: push_data};
                slot_vld[tail] <= 1'b1;
                tail           <= PW'(ring_add(int'(tail), 1, DEPTH));
            end
            if (pop) begin
                slot_vld[head] <= 1'b0;
                head           <= PW'(ring_add(int'(head), 1, DEPTH));
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_addr[g] = mem_q[g].addr;
        assign slot_data[g] = mem_q[g].data;
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R2: occupancy never exceeds the number of slots
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: nothing is drained from an empty queue
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/sqb_match.sv
module sqb_match
    import sqb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [ADDR_W-1:0] look_addr,
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [DATA_W-1:0] slot_data [DEPTH],
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [PW-1:0]     head,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);

    // Walk slots from oldest to youngest; a later match overrides an
    // earlier one, so the youngest matching store wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int age = 0; age < DEPTH; age++) begin
            logic [PW-1:0] s;
            s = PW'(ring_add(int'(head), age, DEPTH));
            if (slot_vld[s] && (slot_addr[s] == look_addr)) begin
                hit      = 1'b1;
                hit_data = slot_data[s];
            end
        end
    end

endmodule

// File: rtl/sqb_port_ctrl.sv
module sqb_port_ctrl
    import sqb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter bit WAIT_EMPTY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              q_empty,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pop,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fwd
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    port_state_e state;
    xact_t       xq;
    logic        rd_take;
    logic        use_fwd;
    logic        rd_may_go;

    // A read is not taken again in the cycle its result is presented
    assign rd_take   = rd_valid && !rd_done;
    assign use_fwd   = !WAIT_EMPTY && hit;
    assign rd_may_go = !WAIT_EMPTY || q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PORT_IDLE;
            xq      <= '0;
            rd_done <= 1'b0;
            rd_fwd  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_done <= 1'b0;
            rd_fwd  <= 1'b0;
            unique case (state)
                PORT_IDLE: begin
                    if (rd_take && use_fwd) begin
                        rd_done <= 1'b1;
                        rd_fwd  <= 1'b1;
                        rd_data <= hit_data;
                    end else if (rd_take && rd_may_go) begin
                        state   <= PORT_READ;
                        xq.addr <= rd_addr;
                    end else if (!q_empty) begin
                        state    <= PORT_WRITE;
                        xq.addr  <= head_addr;
                        xq.wdata <= head_data;
                    end
                end
                PORT_READ: begin
                    if (mem_ack) begin
                        state   <= PORT_IDLE;
                        rd_done <= 1'b1;
                        rd_data <= mem_rdata;
                    end
                end
                PORT_WRITE: begin
                    if (mem_ack) begin
                        state <= PORT_IDLE;
                    end
                end
                default: state <= PORT_IDLE;
            endcase
        end
    end

    assign mem_req   = (state != PORT_IDLE);
    assign mem_we    = (state == PORT_WRITE);
    assign mem_addr  = xq.addr;
    assign mem_wdata = xq.wdata;
    assign pop       = (state == PORT_WRITE) && mem_ack;

    // R9: a request stays put until it is acknowledged
    a_r9_req_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R4: a forwarded read finishes next cycle without touching memory
    a_r4_fwd_no_mem: assert property (@(posedge clk) disable iff (rst)
        (!WAIT_EMPTY && state == PORT_IDLE && rd_take && hit)
        |=> (rd_done && rd_fwd && !mem_req));

    // R6: a non-matching read wins the idle port over queued stores
    a_r6_read_first: assert property (@(posedge clk) disable iff (rst)
        (!WAIT_EMPTY && state == PORT_IDLE && rd_take && !hit)
        |=> (mem_req && !mem_we && mem_addr == $past(rd_addr)));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

endmodule

// File: rtl/store_queue_bypass.sv
module store_queue_bypass
    import sqb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 4,
    parameter bit WAIT_EMPTY = 1'b0,
    localparam int PW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fwd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_vld;
    logic [PW-1:0]     head;
    logic [CW-1:0]     count;
    logic              full, empty, push, pop, hit;
    logic [DATA_W-1:0] hit_data;

    assign st_ready = !full;
    assign push     = st_valid && !full;

    sqb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk, .rst, .push, .push_addr(st_addr), .push_data(st_data), .pop,
        .slot_addr, .slot_data, .slot_vld, .head, .count, .full, .empty
    );

    sqb_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
        .look_addr(rd_addr), .slot_addr, .slot_data, .slot_vld, .head,
        .hit, .hit_data
    );

    sqb_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_EMPTY(WAIT_EMPTY)) u_ctrl (
        .clk, .rst, .rd_valid, .rd_addr, .hit, .hit_data, .q_empty(empty),
        .head_addr(slot_addr[head]), .head_data(slot_data[head]),
        .mem_ack, .mem_rdata, .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .pop, .rd_done, .rd_data, .rd_fwd
    );

    // R2: a refused store leaves occupancy unable to grow
    a_r2_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (count <= $past(count)));

    // R7: in ordered mode a memory read only runs with an empty queue
    a_r7_read_when_empty: assert property (@(posedge clk) disable iff (rst)
        (WAIT_EMPTY && mem_req && !mem_we) |-> empty);

    // R3: a slot is freed only by a write acknowledge
    a_r3_free_on_ack: assert property (@(posedge clk) disable iff (rst)
        (count < $past(count)) |-> $past(mem_ack && mem_we));

endmodule

// File: tb/tb_store_queue_bypass.sv
module tb_sqb_mem #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ack,
    output logic [DATA_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] log_addr [64];
    logic [DATA_W-1:0] log_data [64];
    logic              log_we   [64];
    int                log_n;
    int                cnt;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            cnt       <= 0;
            log_n     <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_req && !hold) begin
            if (cnt == LAT - 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= {16'hC0DE, mem_addr};
                if (log_n < 64) begin
                    log_addr[log_n] <= mem_addr;
                    log_data[log_n] <= mem_wdata;
                    log_we[log_n]   <= mem_we;
                    log_n           <= log_n + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end
endmodule

module tb_store_queue_bypass;
    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] a0; logic [DW-1:0] d0;
        logic [AW-1:0] a1; logic [DW-1:0] d1;
        logic [AW-1:0] a2; logic [DW-1:0] d2;
        logic [AW-1:0] ra; logic [DW-1:0] exp; logic fwd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 32'hA0000001, 16'h0020, 32'hA0000002, 16'h0030, 32'hA0000003, 16'h0020, 32'hA0000002, 1'b1},
        '{16'h0011, 32'hB0000001, 16'h0012, 32'hB0000002, 16'h0013, 32'hB0000003, 16'h0013, 32'hB0000003, 1'b1},
        '{16'h0033, 32'hC0000001, 16'h0040, 32'hC0000002, 16'h0040, 32'hC0000003, 16'h0040, 32'hC0000003, 1'b1},
        '{16'h0050, 32'hD0000001, 16'h0051, 32'hD0000002, 16'h0052, 32'hD0000003, 16'h0099, 32'hC0DE0099, 1'b0},
        '{16'h0007, 32'hE0000001, 16'h0008, 32'hE0000002, 16'h0009, 32'hE0000003, 16'h0007, 32'hC0DE0007, 1'b0},
        '{16'h0060, 32'hF0000001, 16'h0060, 32'hF0000002, 16'h0061, 32'hF0000003, 16'h0060, 32'hF0000002, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // main instance (bypass mode)
    logic          st_valid = 1'b0, rd_valid = 1'b0, hold0 = 1'b0;
    logic [AW-1:0] st_addr = '0, rd_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready, rd_done, rd_fwd, mem_req, mem_we, mem_ack;
    logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    // ordered instance
    logic          st1_valid = 1'b0, rd1_valid = 1'b0, hold1 = 1'b0;
    logic [AW-1:0] st1_addr = '0, rd1_addr = '0;
    logic [DW-1:0] st1_data = '0;
    logic          st1_ready, rd1_done, rd1_fwd, mem1_req, mem1_we, mem1_ack;
    logic [DW-1:0] rd1_data, mem1_wdata, mem1_rdata;
    logic [AW-1:0] mem1_addr;

    store_queue_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .WAIT_EMPTY(1'b0)) dut (
        .clk, .rst, .st_valid, .st_addr, .st_data, .st_ready,
        .rd_valid, .rd_addr, .rd_done, .rd_data, .rd_fwd,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
    );
    tb_sqb_mem #(.ADDR_W(AW), .DATA_W(DW), .LAT(3)) mem0 (
        .clk, .rst, .hold(hold0), .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .mem_ack, .mem_rdata
    );

    store_queue_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .WAIT_EMPTY(1'b1)) dut_ord (
        .clk, .rst, .st_valid(st1_valid), .st_addr(st1_addr), .st_data(st1_data),
        .st_ready(st1_ready), .rd_valid(rd1_valid), .rd_addr(rd1_addr),
        .rd_done(rd1_done), .rd_data(rd1_data), .rd_fwd(rd1_fwd),
        .mem_req(mem1_req), .mem_we(mem1_we), .mem_addr(mem1_addr),
        .mem_wdata(mem1_wdata), .mem_ack(mem1_ack), .mem_rdata(mem1_rdata)
    );
    tb_sqb_mem #(.ADDR_W(AW), .DATA_W(DW), .LAT(3)) mem1 (
        .clk, .rst, .hold(hold1), .mem_req(mem1_req), .mem_we(mem1_we),
        .mem_addr(mem1_addr), .mem_wdata(mem1_wdata), .mem_ack(mem1_ack),
        .mem_rdata(mem1_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store0(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic store1(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st1_valid = 1'b1; st1_addr = a; st1_data = d;
        while (!st1_ready) @(negedge clk);
        @(negedge clk);
        st1_valid = 1'b0;
    endtask

    task automatic log_chk0(input int idx, input logic we, input logic [AW-1:0] a,
                            input string req);
        chk(mem0.log_we[idx] == we && mem0.log_addr[idx] == a, req,
            {15'd0, mem0.log_we[idx], mem0.log_addr[idx]}, {15'd0, we, a});
    endtask

    task automatic log_chk1(input int idx, input logic we, input logic [AW-1:0] a,
                            input string req);
        chk(mem1.log_we[idx] == we && mem1.log_addr[idx] == a, req,
            {15'd0, mem1.log_we[idx], mem1.log_addr[idx]}, {15'd0, we, a});
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(st_ready == 1'b1, "R1 st_ready", {31'd0, st_ready}, 32'd1);
        chk(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk(rd_done == 1'b0, "R1 rd_done", {31'd0, rd_done}, 32'd0);

        // Table walk: R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            logic [DW-1:0] got_d;
            logic          got_f;
            hold0 = 1'b1;
            store0(VECS[v].a0, VECS[v].d0);
            store0(VECS[v].a1, VECS[v].d1);
            store0(VECS[v].a2, VECS[v].d2);
            base = mem0.log_n;
            rd_valid = 1'b1; rd_addr = VECS[v].ra;
            @(negedge clk);
            hold0 = 1'b0;
            while (!rd_done) @(negedge clk);
            got_d = rd_data; got_f = rd_fwd;
            rd_valid = 1'b0;
            chk(got_d == VECS[v].exp, VECS[v].fwd ? "R5 R4 fwd data" : "R8 mem data",
                got_d, VECS[v].exp);
            chk(got_f == VECS[v].fwd, "R4 R8 fwd flag", {31'd0, got_f}, {31'd0, VECS[v].fwd});
            repeat (30) @(negedge clk);
            log_chk0(base, 1'b1, VECS[v].a0, "R3 head write first");
            if (VECS[v].fwd) begin
                chk(mem0.log_n == base + 3, "R4 no mem read", mem0.log_n, base + 3);
                log_chk0(base + 1, 1'b1, VECS[v].a1, "R3 order");
                log_chk0(base + 2, 1'b1, VECS[v].a2, "R3 order");
            end else begin
                chk(mem0.log_n == base + 4, "R6 one read", mem0.log_n, base + 4);
                log_chk0(base + 1, 1'b0, VECS[v].ra, "R6 read bypasses writes");
                log_chk0(base + 2, 1'b1, VECS[v].a1, "R3 order");
                log_chk0(base + 3, 1'b1, VECS[v].a2, "R3 order");
            end
        end

        // R2: full queue stalls a fifth store; R9: request held during stall
        hold0 = 1'b1;
        base = mem0.log_n;
        for (int i = 0; i < 4; i++) store0(16'h0100 + 16'(i), 32'h5000_0000 + 32'(i));
        chk(st_ready == 1'b0, "R2 full", {31'd0, st_ready}, 32'd0);
        st_valid = 1'b1; st_addr = 16'h0104; st_data = 32'h5000_0004;
        repeat (4) @(negedge clk);
        chk(st_ready == 1'b0, "R2 still stalled", {31'd0, st_ready}, 32'd0);
        chk(mem_req && mem_we && mem_addr == 16'h0100 && mem_wdata == 32'h5000_0000,
            "R9 held request", {16'd0, mem_addr}, 32'h0100);
        hold0 = 1'b0;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(mem0.log_n == base + 5, "R2 five writes", mem0.log_n, base + 5);
        for (int i = 0; i < 5; i++) log_chk0(base + i, 1'b1, 16'h0100 + 16'(i), "R3 fifo order");
        chk(mem0.log_data[base + 4] == 32'h5000_0004, "R2 stalled store kept",
            mem0.log_data[base + 4], 32'h5000_0004);

        // R7: ordered mode drains first and never forwards
        hold1 = 1'b1;
        store1(16'h0200, 32'h7000_0000);
        store1(16'h0201, 32'h7000_0001);
        rd1_valid = 1'b1; rd1_addr = 16'h0201;
        @(negedge clk);
        hold1 = 1'b0;
        while (!rd1_done) @(negedge clk);
        chk(rd1_data == 32'hC0DE0201, "R7 data from memory", rd1_data, 32'hC0DE0201);
        chk(rd1_fwd == 1'b0, "R7 no forwarding", {31'd0, rd1_fwd}, 32'd0);
        rd1_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(mem1.log_n == 3, "R7 three transactions", mem1.log_n, 3);
        log_chk1(0, 1'b1, 16'h0200, "R7 writes first");
        log_chk1(1, 1'b1, 16'h0201, "R7 writes first");
        log_chk1(2, 1'b0, 16'h0201, "R7 read last");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule